// File: doc/BRIEF.md
# Selectable-Code Parallel Output Encoder

This block turns a signed measurement, already scaled to output units, into a 16-line parallel word for a host or a panel display. It also drives a polarity line, an overflow line and four parity lines. Several run-time settings control it:

- which of five number codes is used;
- how many low data lines are valid;
- whether parity is generated, and whether it covers each 4-bit group or the whole word;
- whether parity makes the count of ones odd or even;
- the logic sense of the data group and of the flag group, set independently.

All conversion is combinational. The physical line levels are captured in one output register, which loads only when the strobe `load` is high at a rising clock edge. Outputs change in the cycle after that edge.

A value outside the selected code's range raises overflow and is clamped to the nearest limit before conversion. An upstream flag that marks the input as outside the usable span raises overflow without altering the data.

Top module: `par_code_enc`

## Requirements
- R1: While `rst_n` is low, every output line is 0.
- R2: Outputs change only on a rising edge where `load` is 1; otherwise they keep their value.
- R3: Code 0 (decimal) drives the magnitude as four BCD digits, with units in bits 3:0, tens in 7:4, hundreds in 11:8 and thousands in 15:12. Its range is -9999 to 9999.
- R4: Code 1 drives the 16-bit magnitude of the value in plain binary. Its range is -32767 to 32767.
- R5: Code 2 (offset binary, range 0 to 65535) and code 3 (two's complement, range -32768 to 32767) drive the low 16 bits of the value.
- R6: Code 4 drives the Gray code of the value, computed as v XOR (v>>1). Its range is 0 to 65535.
- R7: A value outside the selected range sets overflow, and the data shows the nearest range limit in that code.
- R8: `range_err` high sets overflow and leaves the data unchanged.
- R9: Code values 5 to 7 give overflow and all-zero logical data.
- R10: `width_sel` 0, 1, 2 and 3 keep the low 16, 14, 12 and 10 lines; any other value keeps 8. Lines above the kept width are logical 0.
- R11: Parity mode 1 sets `par_o[g]` from data bits 4g+3:4g. The parity bit makes the count of ones in the group plus the parity bit odd when `par_even`=0, and even when `par_even`=1.
- R12: Parity mode 2 drives one parity value, taken over all valid data bits, on all four lines. Modes 0 and 3 drive logical 0 on all four lines.
- R13: `data_inv`=1 inverts the data and parity lines. `flag_inv`=1 inverts the polarity and overflow lines. Each setting leaves the other group unaffected.
- R14: The polarity line is logical 1 exactly when the value is negative, in every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Output register load strobe |
| value | input | VAL_W | Signed scaled measurement |
| range_err | input | 1 | Input outside usable span |
| code_sel | input | 3 | Number code select |
| width_sel | input | 3 | Valid data width select |
| par_mode | input | 2 | Parity mode: off, per group, common |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| data_inv | input | 1 | Invert data and parity lines |
| flag_inv | input | 1 | Invert polarity and overflow lines |
| data_o | output | 16 | Parallel data lines |
| par_o | output | 4 | Parity lines |
| pol_o | output | 1 | Polarity line |
| ovf_o | output | 1 | Overflow line |

## Verification
Clamping, width truncation and parity all act in the same conversion cycle. The checks therefore focus on cases where they meet.

- Out-of-range values are loaded with parity enabled. The parity must reflect the clamped limit, not the raw value.
- Narrow widths are loaded together with group and common parity. Masked groups must count as zeros.
- The inversion settings are applied alongside truncation. The unused lines must then sit at their inverted inactive level.

Every expected word is worked out by hand from the requirements.

// File: rtl/par_code_enc.sv
module par_code_enc #(
  parameter int VAL_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [VAL_W-1:0] value,
  input  logic                    range_err,
  input  logic [2:0]              code_sel,
  input  logic [2:0]              width_sel,
  input  logic [1:0]              par_mode,
  input  logic                    par_even,
  input  logic                    data_inv,
  input  logic                    flag_inv,
  output logic [15:0]             data_o,
  output logic [3:0]              par_o,
  output logic                    pol_o,
  output logic                    ovf_o
);
  localparam int DW = 16;
  localparam int NG = DW / 4;
  localparam int ND = DW / 3 + 1;

  logic signed [VAL_W-1:0] lo, hi, sat;
  logic                    bad_code, below, above, ovf, neg;
  logic [DW-1:0]           mag, sat_w, cdata, mask, ldata;
  logic [4*ND-1:0]         bcd;
  logic [NG-1:0]           grp_par, pbit;

  always_comb begin
    bad_code = 1'b0;
    case (code_sel)
      3'd0: begin lo = VAL_W'(-9999);  hi = VAL_W'(9999);  end
      3'd1: begin lo = VAL_W'(-32767); hi = VAL_W'(32767); end
      3'd2: begin lo = VAL_W'(0);      hi = VAL_W'(65535); end
      3'd3: begin lo = VAL_W'(-32768); hi = VAL_W'(32767); end
      3'd4: begin lo = VAL_W'(0);      hi = VAL_W'(65535); end
      default: begin lo = '0; hi = '0; bad_code = 1'b1; end
    endcase
  end

  assign below = value < lo;
  assign above = value > hi;
  assign sat   = below ? lo : (above ? hi : value);
  assign ovf   = below | above | range_err | bad_code;
  assign neg   = value[VAL_W-1];
  assign sat_w = sat[DW-1:0];
  assign mag   = sat[VAL_W-1] ? DW'(-sat) : sat_w;

  always_comb begin
    bcd = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      for (int d = 0; d < ND; d++)
        if (bcd[4*d +: 4] >= 4'd5) bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      bcd = {bcd[4*ND-2:0], mag[i]};
    end
  end

  always_comb begin
    case (code_sel)
      3'd0:    cdata = bcd[DW-1:0];
      3'd1:    cdata = mag;
      3'd2,
      3'd3:    cdata = sat_w;
      3'd4:    cdata = sat_w ^ (sat_w >> 1);
      default: cdata = '0;
    endcase
    case (width_sel)
      3'd0:    mask = 16'hFFFF;
      3'd1:    mask = 16'h3FFF;
      3'd2:    mask = 16'h0FFF;
      3'd3:    mask = 16'h03FF;
      default: mask = 16'h00FF;
    endcase
  end

  assign ldata = cdata & mask;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_par[g] = ^ldata[4*g +: 4];
  end

  always_comb begin
    case (par_mode)
      2'd1:    pbit = grp_par ^ {NG{~par_even}};
      2'd2:    pbit = {NG{(^ldata) ^ ~par_even}};
      default: pbit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      par_o  <= '0;
      pol_o  <= 1'b0;
      ovf_o  <= 1'b0;
    end else if (load) begin
      data_o <= ldata ^ {DW{data_inv}};
      par_o  <= pbit ^ {NG{data_inv}};
      pol_o  <= neg ^ flag_inv;
      ovf_o  <= ovf ^ flag_inv;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (data_o == '0 && par_o == '0 && !pol_o && !ovf_o)); // R1
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(data_o) && $stable(par_o) && $stable(pol_o) && $stable(ovf_o))); // R2
  AST_FLAG_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    load && range_err |=> ovf_o != $past(flag_inv)); // R8
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    load && code_sel > 3'd4 |=> (ovf_o != $past(flag_inv)) && (data_o == {DW{$past(data_inv)}})); // R9
  AST_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    load && width_sel >= 3'd4 |=> data_o[15:8] == {8{$past(data_inv)}}); // R10
  AST_PAR_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
    load && par_mode == 2'd2 |=> (par_o == 4'h0 || par_o == 4'hF)); // R12
  AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    load && (par_mode == 2'd0 || par_mode == 2'd3) |=> par_o == {NG{$past(data_inv)}}); // R12
  AST_POL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pol_o == ($past(value[VAL_W-1]) ^ $past(flag_inv))); // R14
endmodule

// File: tb/sim_par_code_enc.sv
module sim_par_code_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic signed [17:0] value = '0;
  logic range_err = 1'b0;
  logic [2:0] code_sel = '0, width_sel = '0;
  logic [1:0] par_mode = '0;
  logic par_even = 1'b0, data_inv = 1'b0, flag_inv = 1'b0;
  logic [15:0] data_o;
  logic [3:0] par_o;
  logic pol_o, ovf_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  par_code_enc #(.VAL_W(18)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .value(value), .range_err(range_err),
    .code_sel(code_sel), .width_sel(width_sel), .par_mode(par_mode), .par_even(par_even),
    .data_inv(data_inv), .flag_inv(flag_inv),
    .data_o(data_o), .par_o(par_o), .pol_o(pol_o), .ovf_o(ovf_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input int v, input int code, input int w, input int pm,
                       input bit pe, input bit di, input bit fi, input bit re);
    @(negedge clk);
    value = 18'(v); code_sel = 3'(code); width_sel = 3'(w); par_mode = 2'(pm);
    par_even = pe; data_inv = di; flag_inv = fi; range_err = re;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [15:0] d, input logic [3:0] p,
                            input bit pol, input bit ovf);
    chk({tag, " data"}, 32'(data_o), 32'(d));
    chk({tag, " parity"}, 32'(par_o), 32'(p));
    chk({tag, " pol"}, 32'(pol_o), 32'(pol));
    chk({tag, " ovf"}, 32'(ovf_o), 32'(ovf));
  endtask

  task automatic t_reset;
    load = 1'b1; value = 18'sd1234;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 16'h0000, 4'h0, 1'b0, 1'b0);
    load = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bcd;
    apply(1234, 0, 0, 0, 0, 0, 0, 0);   expect_out("R3 bcd 1234", 16'h1234, 4'h0, 1'b0, 1'b0);
    apply(-9999, 0, 0, 0, 0, 0, 0, 0);  expect_out("R3 R14 bcd -9999", 16'h9999, 4'h0, 1'b1, 1'b0);
    apply(10000, 0, 0, 0, 0, 0, 0, 0);  expect_out("R7 bcd clamp", 16'h9999, 4'h0, 1'b0, 1'b1);
  endtask

  task automatic t_binary;
    apply(-300, 1, 0, 0, 0, 0, 0, 0);    expect_out("R4 sign-mag -300", 16'h012C, 4'h0, 1'b1, 1'b0);
    apply(-32768, 1, 0, 0, 0, 0, 0, 0);  expect_out("R7 sign-mag clamp", 16'h7FFF, 4'h0, 1'b1, 1'b1);
    apply(43981, 2, 0, 0, 0, 0, 0, 0);   expect_out("R5 offset ABCD", 16'hABCD, 4'h0, 1'b0, 1'b0);
    apply(-1, 2, 0, 0, 0, 0, 0, 0);      expect_out("R7 R14 offset below", 16'h0000, 4'h0, 1'b1, 1'b1);
    apply(-2, 3, 0, 0, 0, 0, 0, 0);      expect_out("R5 twos -2", 16'hFFFE, 4'h0, 1'b1, 1'b0);
    apply(32768, 3, 0, 0, 0, 0, 0, 0);   expect_out("R7 twos clamp", 16'h7FFF, 4'h0, 1'b0, 1'b1);
  endtask

  task automatic t_gray;
    apply(255, 4, 0, 0, 0, 0, 0, 0);     expect_out("R6 gray 00FF", 16'h0080, 4'h0, 1'b0, 1'b0);
    apply(32768, 4, 0, 0, 0, 0, 0, 0);   expect_out("R6 gray 8000", 16'hC000, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_flags;
    apply(42, 0, 0, 0, 0, 0, 0, 1);      expect_out("R8 range flag", 16'h0042, 4'h0, 1'b0, 1'b1);
    apply(100, 5, 0, 0, 0, 0, 0, 0);     expect_out("R9 code 5", 16'h0000, 4'h0, 1'b0, 1'b1);
    apply(0, 7, 0, 0, 0, 0, 0, 0);       expect_out("R9 code 7", 16'h0000, 4'h0, 1'b0, 1'b1);
  endtask

  task automatic t_width;
    apply(43981, 2, 4, 0, 0, 0, 0, 0);   expect_out("R10 8 bits", 16'h00CD, 4'h0, 1'b0, 1'b0);
    apply(43981, 2, 2, 0, 0, 0, 0, 0);   expect_out("R10 12 bits", 16'h0BCD, 4'h0, 1'b0, 1'b0);
    apply(43981, 2, 1, 0, 0, 0, 0, 0);   expect_out("R10 14 bits", 16'h2BCD, 4'h0, 1'b0, 1'b0);
    apply(43981, 2, 7, 0, 0, 0, 0, 0);   expect_out("R10 code 7 width", 16'h00CD, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_parity;
    apply(1234, 0, 0, 1, 0, 0, 0, 0);    expect_out("R11 group odd", 16'h1234, 4'b0010, 1'b0, 1'b0);
    apply(1234, 0, 0, 1, 1, 0, 0, 0);    expect_out("R11 group even", 16'h1234, 4'b1101, 1'b0, 1'b0);
    apply(43981, 2, 4, 1, 0, 0, 0, 0);   expect_out("R11 R10 group narrow", 16'h00CD, 4'b1110, 1'b0, 1'b0);
    apply(1234, 0, 0, 2, 0, 0, 0, 0);    expect_out("R12 common odd", 16'h1234, 4'h0, 1'b0, 1'b0);
    apply(1234, 0, 0, 2, 1, 0, 0, 0);    expect_out("R12 common even", 16'h1234, 4'hF, 1'b0, 1'b0);
    apply(43981, 2, 4, 2, 1, 0, 0, 0);   expect_out("R12 R10 common narrow", 16'h00CD, 4'hF, 1'b0, 1'b0);
    apply(1234, 0, 0, 3, 1, 0, 0, 0);    expect_out("R12 mode 3 off", 16'h1234, 4'h0, 1'b0, 1'b0);
    apply(40000, 1, 0, 1, 0, 0, 0, 0);   expect_out("R7 R11 clamp parity", 16'h7FFF, 4'b0111, 1'b0, 1'b1);
  endtask

  task automatic t_invert;
    apply(1234, 0, 0, 1, 0, 1, 0, 0);    expect_out("R13 data inv", 16'hEDCB, 4'b1101, 1'b0, 1'b0);
    apply(-5, 0, 0, 0, 0, 0, 1, 0);      expect_out("R13 flag inv", 16'h0005, 4'h0, 1'b0, 1'b1);
    apply(43981, 2, 4, 0, 0, 1, 0, 0);   expect_out("R13 R10 inv narrow", 16'hFF32, 4'hF, 1'b1 ^ 1'b1, 1'b0);
  endtask

  task automatic t_hold;
    apply(1234, 0, 0, 1, 0, 0, 0, 0);
    value = 18'sd77; code_sel = 3'd2; par_mode = 2'd2; data_inv = 1'b1; flag_inv = 1'b1; range_err = 1'b1;
    repeat (5) @(negedge clk);
    expect_out("R2 hold", 16'h1234, 4'b0010, 1'b0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bcd();
    t_binary();
    t_gray();
    t_flags();
    t_width();
    t_parity();
    t_invert();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule